// File: doc/BRIEF.md
# Programmable Base-Address Window Decoder

This block places a device's memory window inside a 24-bit or 32-bit bus address space. Software programs a 16-bit base offset through a small register port, using either one word write or two byte writes. The decoder then checks each incoming address against that offset. A mode input selects the address space. In 24-bit mode the offset covers address lines 23..8. In 32-bit mode it covers lines 31..16.

A 4-bit size input decides how many offset bits take part in the compare: the top `size+1` bits are compared and the lower offset bits are ignored, so a larger size gives a smaller window. When a qualified address strobe carries the expected address-space code and the compared bits agree, the block raises a registered select one clock later. A hard reset clears the offset. A soft reset drops the select but keeps the offset.

Top module: `addr_window_decoder`

## Requirements
- R1: While `hard_rst` is high at a clock edge, the offset becomes 0x0000 and `sel` becomes 0. Hard reset takes priority over every write.
- R2: `soft_rst` leaves the offset unchanged and forces `sel` to 0 on the following cycle, even if a matching decode is presented at the same time.
- R3: A word write (`reg_byte`=0) at register address 0x6 loads all 16 offset bits from `reg_wdata`. `reg_rdata` returns the offset whenever `reg_addr` is 0x6 or 0x7, and 0 for any other address. Reads change nothing.
- R4: A byte write (`reg_byte`=1) at address 0x6 loads offset[15:8] from `reg_wdata[7:0]` and keeps offset[7:0].
- R5: A byte write at address 0x7 loads offset[7:0] from `reg_wdata[7:0]` and keeps offset[15:8].
- R6: Writes to any address other than 0x6 or 0x7 are ignored, and so are word writes at 0x7. In both cases the offset keeps its value.
- R7: In 24-bit mode (`mode_a32`=0), offset[15:0] is compared with address lines 23..8. Lines 31..24 play no part.
- R8: In 32-bit mode (`mode_a32`=1), offset[15:0] is compared with address lines 31..16.
- R9: Only the `size+1` most significant offset bits are compared. A `size` of 0 compares offset bit 15 alone, and a `size` of 15 compares all 16 bits.
- R10: `sel` rises one cycle after a cycle in which `bus_avalid`=1 and the compare matches, and only if `bus_space` is 2'b01 in 24-bit mode or 2'b10 in 32-bit mode. Otherwise `sel` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high; clears the offset |
| soft_rst | input | 1 | Synchronous soft reset, active high; clears only the select |
| reg_wr | input | 1 | Register write strobe |
| reg_byte | input | 1 | 1 = 8-bit access, 0 = 16-bit access |
| reg_addr | input | 16 | Register port byte address |
| reg_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| reg_rdata | output | 16 | Offset readback |
| mode_a32 | input | 1 | 0 = 24-bit window, 1 = 32-bit window |
| size | input | 4 | Compare width minus one |
| bus_avalid | input | 1 | Address valid strobe |
| bus_space | input | 2 | Address-space code (01 = 24-bit, 10 = 32-bit) |
| bus_addr | input | 24 | Address lines 31..8 |
| sel | output | 1 | Registered window select |

## Verification
The hardest case to reach from the ports is an address that differs from the offset only in bits just below the compare boundary. This case shows whether the mask edge is exactly at `size+1` bits, no more and no fewer. The bench keeps one offset and varies the size and address together. It places mismatches one bit above and one bit below the boundary, in both address modes. It also presents a soft reset in the same cycle as a matching decode, to confirm that the reset wins and the offset survives.

// File: rtl/awd_pkg.sv
package awd_pkg;
   typedef enum logic [1:0] {
      SP_NONE = 2'b00,
      SP_A24  = 2'b01,
      SP_A32  = 2'b10,
      SP_RSVD = 2'b11
   } space_e;

   localparam logic [15:0] OFFSET_REG_ADDR = 16'h0006;
endpackage

// File: rtl/awd_offset_reg.sv
module awd_offset_reg #(
   parameter int unsigned           OFS_W    = 16,
   parameter int unsigned           RA_W     = 16,
   parameter logic [RA_W-1:0]       REG_ADDR = 16'h0006
) (
   input  logic             clk,
   input  logic             hard_rst,
   input  logic             reg_wr,
   input  logic             reg_byte,
   input  logic [RA_W-1:0]  reg_addr,
   input  logic [OFS_W-1:0] reg_wdata,
   output logic [OFS_W-1:0] offset
);
   localparam int unsigned     HALF    = OFS_W / 2;
   localparam logic [RA_W-1:0] LO_ADDR = REG_ADDR + 1'b1;

   logic hit_hi, hit_lo;
   assign hit_hi = (reg_addr == REG_ADDR);
   assign hit_lo = (reg_addr == LO_ADDR);

   always_ff @(posedge clk) begin
      if (hard_rst) begin
         offset <= '0;
      end else if (reg_wr) begin
         if (!reg_byte && hit_hi)
            offset <= reg_wdata;
         else if (reg_byte && hit_hi)
            offset[OFS_W-1:HALF] <= reg_wdata[HALF-1:0];
         else if (reg_byte && hit_lo)
            offset[HALF-1:0] <= reg_wdata[HALF-1:0];
      end
   end
endmodule

// File: rtl/awd_mask_gen.sv
module awd_mask_gen #(
   parameter int unsigned OFS_W  = 16,
   parameter int unsigned SIZE_W = 4
) (
   input  logic [SIZE_W-1:0] size,
   output logic [OFS_W-1:0]  mask
);
   for (genvar i = 0; i < OFS_W; i++) begin : g_bit
      localparam int unsigned DIST = OFS_W - 1 - i;
      assign mask[i] = ({1'b0, size} >= (SIZE_W+1)'(DIST));
   end
endmodule

// File: rtl/awd_compare.sv
module awd_compare
   import awd_pkg::*;
#(
   parameter int unsigned OFS_W   = 16,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned A24_LSB = 8
) (
   input  logic                      clk,
   input  logic                      hard_rst,
   input  logic                      soft_rst,
   input  logic                      mode_a32,
   input  logic                      bus_avalid,
   input  logic [1:0]                bus_space,
   input  logic [ADDR_W-1:A24_LSB]   bus_addr,
   input  logic [OFS_W-1:0]          offset,
   input  logic [OFS_W-1:0]          mask,
   output logic                      sel
);
   logic [OFS_W-1:0] field;
   logic             space_ok, hit;

   assign field    = mode_a32 ? bus_addr[ADDR_W-1 -: OFS_W]
                              : bus_addr[A24_LSB+OFS_W-1 -: OFS_W];
   assign space_ok = mode_a32 ? (bus_space == SP_A32) : (bus_space == SP_A24);
   assign hit      = bus_avalid && space_ok && (((field ^ offset) & mask) == '0);

   always_ff @(posedge clk) begin
      if (hard_rst || soft_rst) sel <= 1'b0;
      else                      sel <= hit;
   end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import awd_pkg::*;
#(
   parameter int unsigned OFS_W  = 16,
   parameter int unsigned SIZE_W = 4,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned A24_W  = 24,
   parameter int unsigned RA_W   = 16
) (
   input  logic                     clk,
   input  logic                     hard_rst,
   input  logic                     soft_rst,
   input  logic                     reg_wr,
   input  logic                     reg_byte,
   input  logic [RA_W-1:0]          reg_addr,
   input  logic [OFS_W-1:0]         reg_wdata,
   output logic [OFS_W-1:0]         reg_rdata,
   input  logic                     mode_a32,
   input  logic [SIZE_W-1:0]        size,
   input  logic                     bus_avalid,
   input  logic [1:0]               bus_space,
   input  logic [ADDR_W-1:A24_W-OFS_W] bus_addr,
   output logic                     sel
);
   localparam int unsigned     A24_LSB  = A24_W - OFS_W;
   localparam logic [RA_W-1:0] REG_ADDR = RA_W'(OFFSET_REG_ADDR);
   localparam logic [RA_W-1:0] LO_ADDR  = REG_ADDR + 1'b1;

   if (OFS_W % 2 != 0) begin : g_bad_even
      $error("OFS_W must be even for byte lanes");
   end
   if ((1 << SIZE_W) < OFS_W) begin : g_bad_size
      $error("SIZE_W too narrow to span OFS_W");
   end
   if (A24_W <= OFS_W || ADDR_W < A24_W) begin : g_bad_addr
      $error("address widths inconsistent with OFS_W");
   end

   logic [OFS_W-1:0] offset, mask;

   awd_offset_reg #(.OFS_W(OFS_W), .RA_W(RA_W), .REG_ADDR(REG_ADDR)) i_reg (
      .clk(clk), .hard_rst(hard_rst), .reg_wr(reg_wr), .reg_byte(reg_byte),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .offset(offset)
   );

   awd_mask_gen #(.OFS_W(OFS_W), .SIZE_W(SIZE_W)) i_mask (
      .size(size), .mask(mask)
   );

   awd_compare #(.OFS_W(OFS_W), .ADDR_W(ADDR_W), .A24_LSB(A24_LSB)) i_cmp (
      .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .mode_a32(mode_a32),
      .bus_avalid(bus_avalid), .bus_space(bus_space), .bus_addr(bus_addr),
      .offset(offset), .mask(mask), .sel(sel)
   );

   assign reg_rdata = (reg_addr == REG_ADDR || reg_addr == LO_ADDR) ? offset : '0;
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
   parameter int unsigned OFS_W = 16,
   parameter int unsigned RA_W  = 16
) (
   input logic             clk,
   input logic             hard_rst,
   input logic             soft_rst,
   input logic             reg_wr,
   input logic             reg_byte,
   input logic [RA_W-1:0]  reg_addr,
   input logic             mode_a32,
   input logic             bus_avalid,
   input logic [1:0]       bus_space,
   input logic             sel,
   input logic [OFS_W-1:0] offset
);
   localparam int unsigned HALF = OFS_W / 2;
   localparam logic [RA_W-1:0] HI_A = RA_W'(16'h0006);
   localparam logic [RA_W-1:0] LO_A = RA_W'(16'h0007);

   a_r1_hard_clears: assert property (@(posedge clk)
      hard_rst |=> (offset == '0) && !sel);

   a_r2_soft_keeps_offset: assert property (@(posedge clk) disable iff (hard_rst)
      soft_rst && !reg_wr |=> $stable(offset));

   a_r2_soft_drops_sel: assert property (@(posedge clk)
      soft_rst |=> !sel);

   a_r4_hi_byte_keeps_lo: assert property (@(posedge clk) disable iff (hard_rst)
      reg_wr && reg_byte && reg_addr == HI_A |=> $stable(offset[HALF-1:0]));

   a_r5_lo_byte_keeps_hi: assert property (@(posedge clk) disable iff (hard_rst)
      reg_wr && reg_byte && reg_addr == LO_A |=> $stable(offset[OFS_W-1:HALF]));

   a_r6_word_at_odd_ignored: assert property (@(posedge clk) disable iff (hard_rst)
      reg_wr && !reg_byte && reg_addr == LO_A |=> $stable(offset));

   a_r10_needs_valid: assert property (@(posedge clk)
      !bus_avalid |=> !sel);

   a_r10_space_a32: assert property (@(posedge clk)
      bus_avalid && mode_a32 && bus_space != 2'b10 |=> !sel);

   a_r10_space_a24: assert property (@(posedge clk)
      bus_avalid && !mode_a32 && bus_space != 2'b01 |=> !sel);
endmodule

bind addr_window_decoder awd_checker #(.OFS_W(OFS_W), .RA_W(RA_W)) i_awd_checker (
   .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .reg_wr(reg_wr),
   .reg_byte(reg_byte), .reg_addr(reg_addr), .mode_a32(mode_a32),
   .bus_avalid(bus_avalid), .bus_space(bus_space), .sel(sel), .offset(offset)
);

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;
   localparam int CLK_P = 10;

   logic        clk = 0;
   logic        hard_rst, soft_rst, reg_wr, reg_byte, mode_a32, bus_avalid;
   logic [15:0] reg_addr, reg_wdata, reg_rdata;
   logic [3:0]  size;
   logic [1:0]  bus_space;
   logic [31:8] bus_addr;
   logic        sel;
   int          checks = 0, errors = 0;
   bit          done = 0;

   always #(CLK_P/2) clk = ~clk;

   addr_window_decoder i_addr_window_decoder (
      .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst), .reg_wr(reg_wr),
      .reg_byte(reg_byte), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mode_a32(mode_a32), .size(size),
      .bus_avalid(bus_avalid), .bus_space(bus_space), .bus_addr(bus_addr),
      .sel(sel)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic exp_match(input logic [15:0] off, input logic [3:0] sz,
                                      input logic [31:0] addr, input logic a32);
      logic [15:0] fld;
      int sh;
      fld = a32 ? addr[31:16] : addr[23:8];
      sh  = 15 - int'(sz);
      return (fld >> sh) == (off >> sh);
   endfunction

   task automatic wr(input logic [15:0] a, input logic byt, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1; reg_byte = byt; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd_check(input string tag, input logic [15:0] a, input logic [15:0] exp);
      @(negedge clk);
      reg_addr = a; #1;
      check(tag, 32'(reg_rdata), 32'(exp));
   endtask

   task automatic decode(input string tag, input logic a32, input logic [3:0] sz,
                         input logic [1:0] sp, input logic v, input logic [31:0] addr,
                         input logic exp);
      @(negedge clk);
      mode_a32 = a32; size = sz; bus_space = sp; bus_avalid = v; bus_addr = addr[31:8];
      @(posedge clk); #1;
      check(tag, 32'(sel), 32'(exp));
      @(negedge clk);
      bus_avalid = 0;
   endtask

   task automatic t_reset;
      rd_check("R1 offset after hard reset", 16'h6, 16'h0000);
      check("R1 sel after hard reset", 32'(sel), 0);
   endtask

   task automatic t_word;
      wr(16'h6, 0, 16'hA5C3);
      rd_check("R3 read at 6", 16'h6, 16'hA5C3);
      rd_check("R3 read at 7", 16'h7, 16'hA5C3);
      rd_check("R3 read elsewhere", 16'h4, 16'h0000);
      rd_check("R3 repeated read", 16'h6, 16'hA5C3);
   endtask

   task automatic t_bytes;
      wr(16'h6, 1, 16'h0012);
      rd_check("R4 high byte write", 16'h6, 16'h12C3);
      wr(16'h7, 1, 16'h0034);
      rd_check("R5 low byte write", 16'h6, 16'h1234);
   endtask

   task automatic t_ignored;
      wr(16'h7, 0, 16'hFFFF);
      rd_check("R6 word write at 7", 16'h6, 16'h1234);
      wr(16'h8, 0, 16'hFFFF);
      rd_check("R6 write at 8", 16'h6, 16'h1234);
      wr(16'h0, 1, 16'h00FF);
      rd_check("R6 byte write at 0", 16'h6, 16'h1234);
   endtask

   task automatic t_a24;
      decode("R7 a24 exact", 0, 15, 2'b01, 1, 32'h0012_3400, exp_match(16'h1234, 15, 32'h0012_3400, 0));
      decode("R7 a24 upper lines ignored", 0, 15, 2'b01, 1, 32'hFF12_34AB, 1);
      decode("R7 a24 miss", 0, 15, 2'b01, 1, 32'h0012_3500, 0);
   endtask

   task automatic t_a32;
      decode("R8 a32 hit", 1, 15, 2'b10, 1, 32'h1234_0000, 1);
      decode("R8 a32 miss", 1, 15, 2'b10, 1, 32'h1235_0000, 0);
      decode("R8 a32 lines 15..8 ignored", 1, 15, 2'b10, 1, 32'h1234_FF00, 1);
   endtask

   task automatic t_size;
      decode("R9 size0 hit", 1, 0, 2'b10, 1, 32'h7FFF_0000, 1);
      decode("R9 size0 miss", 1, 0, 2'b10, 1, 32'h8000_0000, 0);
      decode("R9 size7 below boundary", 1, 7, 2'b10, 1, 32'h12FF_0000, 1);
      decode("R9 size7 at boundary", 1, 7, 2'b10, 1, 32'h1334_0000, 0);
      decode("R9 size8 just inside", 0, 8, 2'b01, 1, 32'h0012_B400, 0);
      decode("R9 size7 a24", 0, 7, 2'b01, 1, 32'h0012_B400,
             exp_match(16'h1234, 7, 32'h0012_B400, 0));
   endtask

   task automatic t_space;
      decode("R10 no valid", 1, 15, 2'b10, 0, 32'h1234_0000, 0);
      decode("R10 wrong space a32", 1, 15, 2'b01, 1, 32'h1234_0000, 0);
      decode("R10 wrong space a24", 0, 15, 2'b10, 1, 32'h0012_3400, 0);
      @(negedge clk);
      mode_a32 = 1; size = 15; bus_space = 2'b10; bus_avalid = 1; bus_addr = 24'h1234_00;
      #1 check("R10 sel not yet risen", 32'(sel), 0);
      @(posedge clk); #1;
      check("R10 sel one cycle later", 32'(sel), 1);
      @(negedge clk); bus_avalid = 0;
   endtask

   task automatic t_soft;
      @(negedge clk);
      mode_a32 = 1; size = 15; bus_space = 2'b10; bus_avalid = 1; bus_addr = 24'h1234_00;
      soft_rst = 1;
      @(posedge clk); #1;
      check("R2 soft reset wins over match", 32'(sel), 0);
      @(negedge clk); soft_rst = 0; bus_avalid = 0;
      rd_check("R2 offset survives soft reset", 16'h6, 16'h1234);
      @(negedge clk);
      hard_rst = 1; reg_wr = 1; reg_byte = 0; reg_addr = 16'h6; reg_wdata = 16'hBEEF;
      @(negedge clk); hard_rst = 0; reg_wr = 0;
      rd_check("R1 hard reset beats write", 16'h6, 16'h0000);
   endtask

   initial begin
      hard_rst = 1; soft_rst = 0; reg_wr = 0; reg_byte = 0; reg_addr = 0; reg_wdata = 0;
      mode_a32 = 0; size = 15; bus_avalid = 0; bus_space = 0; bus_addr = 0;
      repeat (3) @(negedge clk);
      hard_rst = 0;
      t_reset;
      t_word;
      t_bytes;
      t_ignored;
      t_a24;
      t_a32;
      t_size;
      t_space;
      t_soft;
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule